// File: doc/BRIEF.md
# Oscillator Host Register Loader

This block is the processor-facing register front end of a numerically controlled oscillator. A host places bytes on an 8-bit data bus and a 4-bit address bus. It selects the block with an active-low chip select and pulses an active-low write strobe. The block stores each byte in a 32-bit frequency staging buffer or in a 12-bit phase offset register, depending on the address. The host can write the staging bytes in any order, and it only has to rewrite the bytes that changed.

Writing the staging buffer has no effect on the running oscillator. A separate active-low load input, which may be asynchronous to the clock, commits the staged word. The word goes into one of two increment registers, and the select input chooses which one. The same select line also chooses which of the two increment registers drives the accumulator. This lets the host switch between two prepared frequencies with one pin. The accumulator, the waveform lookup and the converter sit downstream of this block.

Top module: `dds_host_loader`

## Requirements
- R1: An active-high reset clears the staging buffer, both increment registers and the phase offset register to zero, so `inc_word` and `phase_word` read 0 after reset.
- R2: A write happens at the first clock edge at which `wr_n` is sampled high after having been sampled low, provided `cs_n` is sampled low at that edge. With address 0..3 the data byte goes into staging byte 0..3, where byte 0 is bits 7..0 and byte 3 is bits 31..24.
- R3: A staging write changes only the addressed byte. The other three bytes keep their values, whatever order the writes come in.
- R4: Addresses 4..7 have no effect on any register.
- R5: While `cs_n` is high, a strobe edge writes nothing.
- R6: Holding `wr_n` high writes nothing further, even if the data or address changes.
- R7: An address with bit 3 high and bit 0 low (for example 1000) copies data bits 7..4 into phase bits 3..0. Phase bits 11..4 stay unchanged.
- R8: An address with bit 3 high and bit 0 high (for example 1001) copies data bits 7..0 into phase bits 11..4. Phase bits 3..0 stay unchanged.
- R9: The load input passes through a two-stage synchronizer. A falling edge of `load_n` applied between clock edges copies the staging buffer at the third following rising clock edge.
- R10: The copy goes into increment register A when `sel_a` is high and into register B when it is low. The other register keeps its value.
- R11: `inc_word` shows register A while `sel_a` is high and register B while it is low. Changing `sel_a` alone alters no stored register.
- R12: Writing the staging buffer does not change `inc_word` until a load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Host data byte |
| bus_addr | input | 4 | Host register address |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, synchronous to clk |
| load_n | input | 1 | Active-low frequency commit, may be asynchronous |
| sel_a | input | 1 | High selects increment register A, low selects B |
| inc_word | output | 32 | Increment driving the accumulator |
| phase_word | output | 12 | Phase offset register contents |

## Verification
The checker assumes that `wr_n`, `cs_n`, the address and the data meet setup to `clk`. It also assumes that `load_n` stays low long enough for the synchronizer to see it. The bench therefore changes every input only at falling clock edges. It holds chip select, address and data steady across the strobe's rising edge, and keeps `load_n` low for four cycles and then high for at least three. Within those limits, the random mix covers all sixteen addresses, writes with and without chip select, and loads into both registers. It also flips the select line between operations.

// File: rtl/dds_host_loader.sv
module dds_host_loader #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int FW = 32,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_data,
  input  logic [AW-1:0] bus_addr,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          load_n,
  input  logic          sel_a,
  output logic [FW-1:0] inc_word,
  output logic [PW-1:0] phase_word
);
  localparam int NB = FW / DW;
  localparam int BW = $clog2(NB);
  localparam int LO = PW - DW;

  logic          wr_q;
  logic [2:0]    ld_sync;
  logic [FW-1:0] fbuf, inc_a, inc_b;
  logic [PW-1:0] pm_reg;

  wire wr_go   = wr_n & ~wr_q & ~cs_n;
  wire pm_hit  = wr_go & bus_addr[AW-1];
  wire fb_hit  = wr_go & (bus_addr[AW-2:BW] == '0) & ~bus_addr[AW-1];
  wire ld_fall = ld_sync[2] & ~ld_sync[1];

  always_ff @(posedge clk)
    if (rst) begin
      wr_q    <= 1'b1;
      ld_sync <= 3'b111;
    end else begin
      wr_q    <= wr_n;
      ld_sync <= {ld_sync[1:0], load_n};
    end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk)
      if (rst)
        fbuf[b*DW +: DW] <= '0;
      else if (fb_hit && bus_addr[BW-1:0] == BW'(b))
        fbuf[b*DW +: DW] <= bus_data;
  end

  always_ff @(posedge clk)
    if (rst)
      pm_reg <= '0;
    else if (pm_hit && bus_addr[0])
      pm_reg[PW-1:LO] <= bus_data;
    else if (pm_hit)
      pm_reg[LO-1:0] <= bus_data[DW-1 -: LO];

  always_ff @(posedge clk)
    if (rst) begin
      inc_a <= '0;
      inc_b <= '0;
    end else if (ld_fall) begin
      if (sel_a) inc_a <= fbuf;
      else       inc_b <= fbuf;
    end

  assign inc_word   = sel_a ? inc_a : inc_b;
  assign phase_word = pm_reg;
endmodule

// File: rtl/dds_host_loader_chk.sv
module dds_host_loader_chk #(
  parameter int FW = 32,
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          wr_n,
  input logic [3:0]    bus_addr,
  input logic          sel_a,
  input logic          ld_fall,
  input logic [FW-1:0] fbuf,
  input logic [FW-1:0] inc_a,
  input logic [FW-1:0] inc_b,
  input logic [FW-1:0] inc_word,
  input logic [PW-1:0] phase_word
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (inc_word == '0 && phase_word == '0 && fbuf == '0));
  // R5
  no_select_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(fbuf) && $stable(phase_word)));
  // R6
  held_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_n && $past(wr_n)) |=> ($stable(fbuf) && $stable(phase_word)));
  // R4
  dead_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[3:2] == 2'b01) |=> ($stable(fbuf) && $stable(phase_word)));
  // R10
  load_a_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_fall && sel_a) |=> (inc_a == $past(fbuf) && $stable(inc_b)));
  // R10
  load_b_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_fall && !sel_a) |=> (inc_b == $past(fbuf) && $stable(inc_a)));
  // R12
  hold_inc_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_fall |=> ($stable(inc_a) && $stable(inc_b)));
endmodule

bind dds_host_loader dds_host_loader_chk #(.FW(FW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .bus_addr(bus_addr),
  .sel_a(sel_a), .ld_fall(ld_fall), .fbuf(fbuf), .inc_a(inc_a),
  .inc_b(inc_b), .inc_word(inc_word), .phase_word(phase_word)
);

// File: tb/tb_dds_host_loader.sv
module tb_dds_host_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, cs_n = 1, wr_n = 1, load_n = 1, sel_a = 0;
  logic [7:0]  bus_data = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] inc_word;
  logic [11:0] phase_word;

  dds_host_loader dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] m_buf = 0, m_a = 0, m_b = 0;
  logic [11:0] m_pm = 0;

  function automatic logic [31:0] exp_inc(logic s);
    return s ? m_a : m_b;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " inc"}, inc_word, exp_inc(sel_a));
    chk({tag, " phase"}, {20'd0, phase_word}, {20'd0, m_pm});
  endtask

  task automatic host_write(logic [3:0] a, logic [7:0] d, logic cs);
    @(negedge clk); bus_addr = a; bus_data = d; cs_n = ~cs; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
    if (cs) begin
      if (a[3] && a[0]) m_pm[11:4] = d;
      else if (a[3]) m_pm[3:0] = d[7:4];
      else if (a[2] == 0) m_buf[a[1:0]*8 +: 8] = d;
    end
  endtask

  task automatic commit(logic s);
    @(negedge clk); sel_a = s; load_n = 0;
    repeat (4) @(negedge clk);
    load_n = 1;
    repeat (3) @(negedge clk);
    if (s) m_a = m_buf; else m_b = m_buf;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 inc", inc_word, 0);
    chk("R1 phase", {20'd0, phase_word}, 0);
    sel_a = 1; @(negedge clk);
    chk("R1 inc A", inc_word, 0);

    // R2 R3 out-of-order bytes, R12 no effect before commit
    host_write(4'd2, 8'h33, 1);
    host_write(4'd0, 8'h11, 1);
    host_write(4'd3, 8'h44, 1);
    host_write(4'd1, 8'h22, 1);
    chk("R12 inc before load", inc_word, 0);
    commit(1);
    chk("R2 R3 load A", inc_word, 32'h44332211);
    chk("R2 model", m_a, 32'h44332211);
    // R3 single byte rewrite
    host_write(4'd1, 8'hAB, 1);
    commit(0);
    sel_a = 0; @(negedge clk);
    chk("R3 byte1 only", inc_word, 32'h4433AB11);
    // R11 select switch alone
    sel_a = 1; @(negedge clk);
    chk("R11 sel A", inc_word, 32'h44332211);
    sel_a = 0; @(negedge clk);
    chk("R11 sel B", inc_word, 32'h4433AB11);
    // R4 dead addresses
    for (int a = 4; a < 8; a++) host_write(4'(a), 8'hEE, 1);
    commit(1);
    chk("R4 dead addr", inc_word, 32'h4433AB11);
    // R5 no select
    host_write(4'd0, 8'h99, 0);
    host_write(4'd9, 8'h99, 0);
    commit(1);
    chk("R5 cs high", inc_word, 32'h4433AB11);
    chk("R5 phase", {20'd0, phase_word}, 0);
    // R7 R8 phase nibble and byte
    host_write(4'd8, 8'hC7, 1);
    chk("R7 low nibble", {20'd0, phase_word}, 32'h00C);
    host_write(4'd9, 8'h5A, 1);
    chk("R8 high byte", {20'd0, phase_word}, 32'h5AC);
    host_write(4'd14, 8'h30, 1);
    chk("R7 addr 1110", {20'd0, phase_word}, 32'h5A3);
    // R6 held strobe
    @(negedge clk); bus_addr = 0; bus_data = 8'h01; cs_n = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); bus_data = 8'h02; bus_addr = 4'd3;
    @(negedge clk); bus_addr = 4'd9;
    @(negedge clk); cs_n = 1;
    m_buf[7:0] = 8'h01;
    chk("R6 phase held", {20'd0, phase_word}, 32'h5A3);
    commit(1);
    chk("R6 held strobe", inc_word, 32'h4433AB01);
    // R9 latency
    host_write(4'd2, 8'h77, 1);
    @(negedge clk); sel_a = 1; load_n = 0;
    @(negedge clk); chk("R9 edge1", inc_word, 32'h4433AB01);
    @(negedge clk); chk("R9 edge2", inc_word, 32'h4433AB01);
    @(negedge clk); chk("R9 edge3", inc_word, 32'h4477AB01);
    @(negedge clk); load_n = 1;
    repeat (3) @(negedge clk);
    m_a = m_buf;
    // random mix
    begin
      int seed = 32'h1357;
      void'($urandom(seed));
    end
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 6)
        host_write(4'($urandom_range(0, 15)), 8'($urandom), $urandom_range(0, 3) != 0);
      else if (op < 8)
        commit(1'($urandom));
      else begin
        @(negedge clk); sel_a = ~sel_a; @(negedge clk);
      end
      chk_all("R2 R10 random");
    end
    rst = 1; @(negedge clk); @(negedge clk);
    chk("R1 rerun", inc_word, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule